// File: doc/BRIEF.md
# Pointer-Addressed Cartridge Memory Mapper

This block sits on the cartridge side of an 8-bit console CPU bus. It watches each CPU bus cycle and latches two 8-bit pointer registers, one low and one high, from the data bus whenever the address falls inside a register window in the lower half of the CPU map. The two registers together form a 16-bit pointer. That pointer addresses a large extended ROM and an extended RAM one byte at a time, so software reaches any byte of those memories through a tiny fixed window instead of through a banked page.

Loading does not depend on the read/write line. A write captures the CPU's data. A read captures whatever byte appears on the bus, which is often a mirror of console work RAM. This allows pointer setup through reads. The upper nibble of the high pointer also chooses one of sixteen 8K character RAM banks. The main program ROM is passed through unbanked, and the mapper gates its enable.

The block runs from a fast system clock that oversamples the CPU phase signal M2. Address and data are sampled while M2 is high. The pointer registers update on the first system clock edge after M2 is seen falling. As a result, an extended-memory access in a given bus cycle always uses the pointer value from before that cycle.

Top module: `ptr_cart_mapper`

## Requirements
- R1: The register window is active only when CPU address bit 15 is 0 and bit 12 is 1. Any access outside the window leaves both pointers unchanged, and the other address bits do not affect the decode.
- R2: Inside the window, address bit 4 set loads the low pointer and address bit 5 set loads the high pointer. With both bits set, both pointers load the same byte.
- R3: Loading ignores R/W (1 = read, 0 = write). A read cycle captures the byte present on the data bus exactly as a write does.
- R4: The extended ROM enable (active low) asserts during M2 high when the window is active, address bit 11 is 1 and bit 2 is 0. Its 17-bit address is {CPU A0, high pointer, low pointer}.
- R5: The extended RAM enable (active low) asserts during M2 high when the window is active, A11 is 1 and A2 is 1. Its address is {high pointer, low pointer}. Its write enable (active low) asserts only on such an access with R/W = 0.
- R6: An extended ROM or RAM access whose address also has bit 4 or bit 5 set loads the matching pointer. The memory address presented during that access is the pointer value from before the load.
- R7: The character bank output equals bits 7..4 of the high pointer.
- R8: The main ROM enable (active low) equals the ROM select strobe (active low) while M2 is high. The main ROM address is the low CPU address bits: 15 bits for 32K, 14 bits for 16K.
- R9: Reset clears both pointers to zero. All chip enables stay inactive whenever M2 is low, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than M2 |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | Byte observed on the CPU data bus |
| cpu_rw | input | 1 | CPU read/write, 1 = read |
| cpu_m2 | input | 1 | CPU phase-2 clock, high during the data phase |
| romsel_n | input | 1 | Upper-half ROM select strobe from the console, active low |
| prg_rom_ce_n | output | 1 | Main ROM chip enable, active low |
| prg_rom_addr | output | 15 | Main ROM address |
| xrom_ce_n | output | 1 | Extended ROM chip enable, active low |
| xrom_addr | output | 17 | Extended ROM address |
| xram_ce_n | output | 1 | Extended RAM chip enable, active low |
| xram_we_n | output | 1 | Extended RAM write enable, active low |
| xram_addr | output | 16 | Extended RAM address |
| chr_bank | output | 4 | Character RAM bank (address bits 16..13) |

## Verification
The hardest case to reach is an extended-memory access that also reloads a pointer. In that cycle the address on the memory pins must still show the old pointer, while the next cycle must show the new one. The stimulus issues accesses at addresses such as 0x1810 and 0x1824, which hit the memory window and a select bit at the same time. The scoreboard then compares the address sampled mid-phase against the bench's pointer model before that model is updated. Read-cycle loads and addresses that fail only one of the two window bits are also driven, and follow-up extended-ROM reads show whether the pointers moved.

// File: rtl/ptr_cart_pkg.sv
package ptr_cart_pkg;

    // address bit roles; positions matter because they are decoded
    localparam int UPPER_BIT   = 15;
    localparam int WIN_EN_BIT  = 12;
    localparam int XSEL_BIT    = 11;
    localparam int XKIND_BIT   = 2;
    localparam int LO_SEL_BIT  = 4;   // pointer i selected by bit LO_SEL_BIT+i
    localparam int NUM_PTR     = 2;   // index 0 = low pointer, 1 = high pointer

    typedef struct packed {
        logic               win;
        logic [NUM_PTR-1:0] ptr_sel;
        logic               xrom;
        logic               xram;
    } dec_t;

endpackage

// File: rtl/ptr_cart_decode.sv
module ptr_cart_decode
    import ptr_cart_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    output dec_t          dec
);

    logic unused_addr;
    assign unused_addr = ^addr;

    always_comb begin
        dec.win = !addr[UPPER_BIT] && addr[WIN_EN_BIT];
        for (int i = 0; i < NUM_PTR; i++) begin
            dec.ptr_sel[i] = dec.win && addr[LO_SEL_BIT + i];
        end
        dec.xrom = dec.win && addr[XSEL_BIT] && !addr[XKIND_BIT];
        dec.xram = dec.win && addr[XSEL_BIT] &&  addr[XKIND_BIT];
    end

endmodule

// File: rtl/ptr_cart_ptr_regs.sv
module ptr_cart_ptr_regs
    import ptr_cart_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         m2,
    input  logic [AW-1:0]                addr,
    input  logic [DW-1:0]                data,
    output logic [NUM_PTR-1:0][DW-1:0]   ptr
);

    typedef struct packed {
        logic                       m2;
        logic [AW-1:0]              addr;
        logic [DW-1:0]              data;
        logic [NUM_PTR-1:0][DW-1:0] ptr;
    } st_t;

    st_t  st_d, st_q;
    dec_t snap_dec;
    logic m2_fall;

    // decode of the bus cycle that was sampled while M2 was high
    ptr_cart_decode #(.AW(AW)) u_snap_dec (
        .addr (st_q.addr),
        .dec  (snap_dec)
    );

    assign m2_fall = st_q.m2 && !m2;

    always_comb begin
        st_d    = st_q;
        st_d.m2 = m2;
        if (m2) begin
            st_d.addr = addr;
            st_d.data = data;
        end
        for (int i = 0; i < NUM_PTR; i++) begin
            if (m2_fall && snap_dec.ptr_sel[i]) begin
                st_d.ptr[i] = st_q.data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;

endmodule

// File: rtl/ptr_cart_addr_map.sv
module ptr_cart_addr_map
    import ptr_cart_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int MAIN_AW = 15,
    parameter int CHR_W   = 4
) (
    input  logic                       m2,
    input  logic                       romsel_n,
    input  logic                       rw,
    input  logic [AW-1:0]              addr,
    input  dec_t                       dec,
    input  logic [NUM_PTR-1:0][DW-1:0] ptr,
    output logic                       prg_rom_ce_n,
    output logic [MAIN_AW-1:0]         prg_rom_addr,
    output logic                       xrom_ce_n,
    output logic [2*DW:0]              xrom_addr,
    output logic                       xram_ce_n,
    output logic                       xram_we_n,
    output logic [2*DW-1:0]            xram_addr,
    output logic [CHR_W-1:0]           chr_bank
);

    logic [2*DW-1:0] full_ptr;
    logic            unused_dec;

    assign unused_dec = ^{dec.win, dec.ptr_sel};

    always_comb begin
        full_ptr     = {ptr[1], ptr[0]};
        prg_rom_ce_n = !(m2 && !romsel_n);
        prg_rom_addr = addr[MAIN_AW-1:0];
        xrom_ce_n    = !(m2 && dec.xrom);
        xrom_addr    = {addr[0], full_ptr};
        xram_ce_n    = !(m2 && dec.xram);
        xram_we_n    = !(m2 && dec.xram && !rw);
        xram_addr    = full_ptr;
        chr_bank     = ptr[1][DW-1 -: CHR_W];
    end

endmodule

// File: rtl/ptr_cart_mapper.sv
module ptr_cart_mapper
    import ptr_cart_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int MAIN_ROM_KB = 32,
    parameter int CHR_W       = 4,
    localparam int MAIN_AW    = $clog2(MAIN_ROM_KB * 1024),
    localparam int XROM_AW    = 2 * DW + 1,
    localparam int XRAM_AW    = 2 * DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      cpu_addr,
    input  logic [DW-1:0]      cpu_data,
    input  logic               cpu_rw,
    input  logic               cpu_m2,
    input  logic               romsel_n,
    output logic               prg_rom_ce_n,
    output logic [MAIN_AW-1:0] prg_rom_addr,
    output logic               xrom_ce_n,
    output logic [XROM_AW-1:0] xrom_addr,
    output logic               xram_ce_n,
    output logic               xram_we_n,
    output logic [XRAM_AW-1:0] xram_addr,
    output logic [CHR_W-1:0]   chr_bank
);

    dec_t                       live_dec;
    logic [NUM_PTR-1:0][DW-1:0] ptr;

    ptr_cart_decode #(.AW(AW)) u_live_dec (
        .addr (cpu_addr),
        .dec  (live_dec)
    );

    ptr_cart_ptr_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .m2    (cpu_m2),
        .addr  (cpu_addr),
        .data  (cpu_data),
        .ptr   (ptr)
    );

    ptr_cart_addr_map #(
        .AW(AW), .DW(DW), .MAIN_AW(MAIN_AW), .CHR_W(CHR_W)
    ) u_map (
        .m2           (cpu_m2),
        .romsel_n     (romsel_n),
        .rw           (cpu_rw),
        .addr         (cpu_addr),
        .dec          (live_dec),
        .ptr          (ptr),
        .prg_rom_ce_n (prg_rom_ce_n),
        .prg_rom_addr (prg_rom_addr),
        .xrom_ce_n    (xrom_ce_n),
        .xrom_addr    (xrom_addr),
        .xram_ce_n    (xram_ce_n),
        .xram_we_n    (xram_we_n),
        .xram_addr    (xram_addr),
        .chr_bank     (chr_bank)
    );

endmodule

// File: rtl/ptr_cart_mapper_chk.sv
module ptr_cart_mapper_chk #(
    parameter int AW = 16,
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_m2,
    input logic [AW-1:0] cpu_addr,
    input logic          prg_rom_ce_n,
    input logic          xrom_ce_n,
    input logic          xram_ce_n,
    input logic          xram_we_n,
    input logic [PW-1:0] xram_addr
);

    assert_idle_when_m2_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_m2 |-> (prg_rom_ce_n && xrom_ce_n && xram_ce_n && xram_we_n));

    assert_ext_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!xrom_ce_n && !xram_ce_n));

    assert_we_needs_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !xram_we_n |-> !xram_ce_n);

    assert_ptr_hold_in_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_m2 && $past(cpu_m2)) |-> $stable(xram_addr));

    assert_no_load_outside_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cpu_m2) && ($past(cpu_addr[15]) || !$past(cpu_addr[12]))) |=> $stable(xram_addr));

endmodule

bind ptr_cart_mapper ptr_cart_mapper_chk #(.AW(AW), .PW(2*DW)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_m2       (cpu_m2),
    .cpu_addr     (cpu_addr),
    .prg_rom_ce_n (prg_rom_ce_n),
    .xrom_ce_n    (xrom_ce_n),
    .xram_ce_n    (xram_ce_n),
    .xram_we_n    (xram_we_n),
    .xram_addr    (xram_addr)
);

// File: tb/ptr_cart_mapper_tb_top.sv
module ptr_cart_mapper_tb_top;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_rw = 1;
    logic        cpu_m2 = 0;
    logic        romsel_n = 1;
    logic        prg_rom_ce_n;
    logic [14:0] prg_rom_addr;
    logic        xrom_ce_n;
    logic [16:0] xrom_addr;
    logic        xram_ce_n;
    logic        xram_we_n;
    logic [15:0] xram_addr;
    logic [3:0]  chr_bank;

    always #10 clk = ~clk;  // 50 MHz

    ptr_cart_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rw(cpu_rw), .cpu_m2(cpu_m2), .romsel_n(romsel_n),
        .prg_rom_ce_n(prg_rom_ce_n), .prg_rom_addr(prg_rom_addr),
        .xrom_ce_n(xrom_ce_n), .xrom_addr(xrom_addr),
        .xram_ce_n(xram_ce_n), .xram_we_n(xram_we_n), .xram_addr(xram_addr),
        .chr_bank(chr_bank)
    );

    typedef struct {
        logic        rom_ce_n;
        logic [14:0] rom_addr;
        logic        xr_ce_n;
        logic [16:0] xr_addr;
        logic        xm_ce_n;
        logic        xm_we_n;
        logic [15:0] xm_addr;
        logic [3:0]  chr;
        string       tag;
    } exp_t;

    exp_t  exp_q[$];
    event  sample_ev;
    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    logic [7:0] m_lo = 0, m_hi = 0;

    task automatic chk(input string tag, input string fld, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, fld, act, exp);
        end
    endtask

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(sample_ev);
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "prg_rom_ce_n", {31'b0, prg_rom_ce_n}, {31'b0, e.rom_ce_n});
                if (!e.rom_ce_n) chk(e.tag, "prg_rom_addr", {17'b0, prg_rom_addr}, {17'b0, e.rom_addr});
                chk(e.tag, "xrom_ce_n", {31'b0, xrom_ce_n}, {31'b0, e.xr_ce_n});
                chk(e.tag, "xrom_addr", {15'b0, xrom_addr}, {15'b0, e.xr_addr});
                chk(e.tag, "xram_ce_n", {31'b0, xram_ce_n}, {31'b0, e.xm_ce_n});
                chk(e.tag, "xram_we_n", {31'b0, xram_we_n}, {31'b0, e.xm_we_n});
                chk(e.tag, "xram_addr", {16'b0, xram_addr}, {16'b0, e.xm_addr});
                chk(e.tag, "chr_bank", {28'b0, chr_bank}, {28'b0, e.chr});
            end
        end
    end

    // driver: one CPU bus cycle, expected values from the requirement model
    task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic rw, input string tag);
        exp_t e;
        logic win, xr, xm;
        win = !a[15] && a[12];
        xr  = win && a[11] && !a[2];
        xm  = win && a[11] &&  a[2];
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rw = rw; romsel_n = !a[15];
        e.tag      = tag;
        e.rom_ce_n = a[15] ? 1'b0 : 1'b1;
        e.rom_addr = a[14:0];
        e.xr_ce_n  = !xr;
        e.xr_addr  = {a[0], m_hi, m_lo};
        e.xm_ce_n  = !xm;
        e.xm_we_n  = !(xm && !rw);
        e.xm_addr  = {m_hi, m_lo};
        e.chr      = m_hi[7:4];
        exp_q.push_back(e);
        cpu_m2 = 1;
        repeat (2) @(negedge clk);
        ->sample_ev;
        @(negedge clk);
        cpu_m2 = 0;
        // M2 low phase: enables idle, pointer not yet updated (R9, R6)
        e.tag      = {tag, " low-phase R9"};
        e.rom_ce_n = 1; e.xr_ce_n = 1; e.xm_ce_n = 1; e.xm_we_n = 1;
        exp_q.push_back(e);
        ->sample_ev;
        repeat (2) @(negedge clk);
        if (win && a[4]) m_lo = d;
        if (win && a[5]) m_hi = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: enables inactive in reset
        chk("R9 reset", "ce", {28'b0, prg_rom_ce_n, xrom_ce_n, xram_ce_n, xram_we_n}, 32'hF);
        rst_n = 1;
        repeat (2) @(negedge clk);
        bus_cycle(16'h1800, 8'h00, 1, "R9 cleared pointer");
        bus_cycle(16'h1010, 8'h34, 0, "R2 load low");
        bus_cycle(16'h1020, 8'h12, 0, "R2 load high");
        bus_cycle(16'h1800, 8'h00, 1, "R4 xrom A0=0 R7");
        bus_cycle(16'h1801, 8'h00, 1, "R4 xrom A0=1");
        bus_cycle(16'h1804, 8'h55, 0, "R5 xram write");
        bus_cycle(16'h1804, 8'h55, 1, "R5 xram read");
        bus_cycle(16'h1030, 8'hA5, 0, "R2 both load");
        bus_cycle(16'h1800, 8'h00, 1, "R2 both check R7");
        bus_cycle(16'h1010, 8'h5C, 1, "R3 read loads");
        bus_cycle(16'h1800, 8'h00, 1, "R3 check");
        bus_cycle(16'h0030, 8'hFF, 0, "R1 A12=0");
        bus_cycle(16'h9030, 8'hEE, 0, "R1 A15=1 R8");
        bus_cycle(16'h2010, 8'h11, 0, "R1 A13 only");
        bus_cycle(16'h1800, 8'h00, 1, "R1 unchanged");
        bus_cycle(16'h5FF0, 8'h3C, 0, "R1 mirror loads");
        bus_cycle(16'h1000, 8'h00, 1, "R4 A11=0 no enable");
        bus_cycle(16'h1810, 8'h77, 1, "R6 xrom+load");
        bus_cycle(16'h1824, 8'h99, 0, "R6 xram+load");
        bus_cycle(16'h1800, 8'h00, 1, "R6 new pointer");
        bus_cycle(16'hC123, 8'h00, 1, "R8 main rom");
        bus_cycle(16'h8000, 8'h00, 1, "R8 main rom base");
        bus_cycle(16'h1020, 8'hF0, 0, "R7 top bank");
        bus_cycle(16'h1800, 8'h00, 1, "R7 bank F");
        done = 1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule